// File: doc/BRIEF.md
# Load/Store Byte-Overlap Conflict Detector

This block keeps a small table of in-flight memory accesses and tells, for each valid entry, which other valid entries it can safely proceed alongside. Each entry records a slice of the access address and the access size in bytes. The lowest address bits and the size are expanded into a byte-coverage bitmap over a 16-byte window. That bitmap is widened so that a misaligned access which runs past the window keeps its overflow bytes. The address bits above the window are compared for equality. Bits above the compared slice are not supplied at all.

Two accesses clash when they lie in the same 16-byte block and their byte bitmaps share a set bit. They also clash when one access spills into the block right above its own and the spilled bytes hit bytes that the other access covers there. The scheduler loads an entry with a one-cycle enable strobe and drops it with a release strobe. It reads a per-entry row of pairwise "free" bits and one summary "free" bit per entry. The match is partial. Addresses that differ only above the compared slice are reported as a clash, which is the safe direction.

Top module: `lsq_overlap_detect`

## Requirements
- R1: While `rst_n` is low and after its release, every entry is invalid, and `free_o` and `free_pair_o` are all zero.
- R2: `lat_en_i[k]` high at a clock edge stores `addr_i[k]` and `len_i[k]` and marks entry k valid. `rel_i[k]` alone marks it invalid. When both are high in the same cycle the enable wins and the entry ends up valid with the new values.
- R3: Address bits [3:0] give the byte offset. A length L from 1 to 8 covers bytes offset to offset+L-1, which is the mask ((1<<L)-1)<<offset in a 24-bit field. Lengths above 8 are treated as 8.
- R4: Two valid entries conflict when address bits [11:4] are equal and their byte masks share at least one bit.
- R5: Mask bits 16 to 23 of an entry whose bits [11:4] equal U are the bytes 0 to 7 of block U+1. They conflict with entries in block U+1 that cover those bytes.
- R6: An entry is never compared with itself. Bit i of row i equals the valid flag of entry i.
- R7: Bit j of row i (`free_pair_o[i][j]`, for j different from i) is high exactly when entry j is valid and does not conflict with entry i. The rows are symmetric between valid entries.
- R8: `free_o[i]` is high exactly when entry i is valid and conflicts with no valid entry.
- R9: A valid entry's stored address and length do not change unless its enable is strobed. Changes on `addr_i`/`len_i` without an enable leave the outputs unchanged.
- R10: A stored length of 0 gives an empty mask. Such an entry conflicts with nothing, and while valid its `free_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | N_ENT x 12 | Per-entry partial address, bits [3:0] byte offset, [11:4] block |
| len_i | input | N_ENT x 4 | Per-entry access length in bytes |
| lat_en_i | input | N_ENT | Per-entry capture strobe |
| rel_i | input | N_ENT | Per-entry release strobe |
| free_pair_o | output | N_ENT x N_ENT | Row i, bit j: entry j valid and not in conflict with entry i |
| free_o | output | N_ENT | Entry valid and free of every conflict |

## Verification
A wrong valid flag appears in the first cycle after the strobe. The self bit of that entry's row and its column in every other row show it at once. A corrupted stored offset, length or block slice appears as a pairwise bit that flips between two entries and as a summary bit that disagrees with the rows. The outputs are combinational from the stored state, so every such fault is visible in the same cycle the state goes wrong. Spill faults appear only when an access crosses a 16-byte boundary, so the directed cases place accesses at offsets 14 and 15 against entries in the next block.

// File: rtl/lsq_overlap_detect.sv
`timescale 1ns/1ps
module lsq_overlap_detect #(
  parameter int N_ENT  = 4,
  parameter int UPW    = 8,
  parameter int OFSW   = 4,
  parameter int LENW   = 4,
  parameter int MAXLEN = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_ENT-1:0][UPW+OFSW-1:0]  addr_i,
  input  logic [N_ENT-1:0][LENW-1:0]      len_i,
  input  logic [N_ENT-1:0]                lat_en_i,
  input  logic [N_ENT-1:0]                rel_i,
  output logic [N_ENT-1:0][N_ENT-1:0]     free_pair_o,
  output logic [N_ENT-1:0]                free_o
);
  localparam int AW  = UPW + OFSW;
  localparam int WIN = 1 << OFSW;
  localparam int MW  = MAXLEN + WIN;

  logic [N_ENT-1:0]           vld;
  logic [N_ENT-1:0][AW-1:0]   addr_q;
  logic [N_ENT-1:0][LENW-1:0] len_q;
  logic [N_ENT-1:0][MW-1:0]   mask;
  logic [N_ENT-1:0][UPW-1:0]  blk;
  logic [N_ENT-1:0][N_ENT-1:0] clash;

  function automatic logic [MW-1:0] mk_mask(input logic [OFSW-1:0] off,
                                            input logic [LENW-1:0] len);
    logic [LENW-1:0] l;
    l = (len > LENW'(MAXLEN)) ? LENW'(MAXLEN) : len;
    return ((MW'(1) << l) - MW'(1)) << off;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      for (int k = 0; k < N_ENT; k++) begin
        if (lat_en_i[k]) begin
          vld[k]    <= 1'b1;
          addr_q[k] <= addr_i[k];
          len_q[k]  <= len_i[k];
        end else if (rel_i[k]) begin
          vld[k] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign mask[i] = mk_mask(addr_q[i][OFSW-1:0], len_q[i]);
    assign blk[i]  = addr_q[i][AW-1:OFSW];
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_row
    for (genvar j = 0; j < N_ENT; j++) begin : g_col
      if (i == j) begin : g_self
        assign clash[i][j] = 1'b0;
      end else begin : g_pair
        logic same, up_ij, up_ji;
        assign same  = (blk[i] == blk[j]) && |(mask[i] & mask[j]);
        assign up_ij = (blk[j] == blk[i] + UPW'(1)) &&
                       |(mask[i][MW-1:WIN] & mask[j][MAXLEN-1:0]);
        assign up_ji = (blk[i] == blk[j] + UPW'(1)) &&
                       |(mask[j][MW-1:WIN] & mask[i][MAXLEN-1:0]);
        assign clash[i][j] = same | up_ij | up_ji;
      end
    end
    assign free_pair_o[i] = vld & ~clash[i];
    assign free_o[i]      = vld[i] & (free_pair_o[i] == vld);
  end
endmodule

module lsq_overlap_detect_chk #(
  parameter int N_ENT = 4,
  parameter int AW    = 12,
  parameter int LENW  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_ENT-1:0]             lat_en_i,
  input logic [N_ENT-1:0]             rel_i,
  input logic [N_ENT-1:0][N_ENT-1:0]  free_pair_o,
  input logic [N_ENT-1:0]             free_o,
  input logic [N_ENT-1:0]             vld,
  input logic [N_ENT-1:0][AW-1:0]     addr_q,
  input logic [N_ENT-1:0][LENW-1:0]   len_q
);
  for (genvar k = 0; k < N_ENT; k++) begin : g_k
    // R2
    enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_en_i[k] |=> free_pair_o[k][k]);
    // R2
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_i[k] && !lat_en_i[k]) |=> (!free_o[k] && !free_pair_o[k][k]));
    // R6
    self_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_pair_o[k][k] == vld[k]);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[k] && !lat_en_i[k]) |=> ($stable(addr_q[k]) && $stable(len_q[k])));
    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[k] && len_q[k] == '0) |-> free_o[k]);
    for (genvar j = 0; j < N_ENT; j++) begin : g_j
      // R7
      symmetry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[k] && vld[j]) |-> (free_pair_o[k][j] == free_pair_o[j][k]));
    end
  end
endmodule

bind lsq_overlap_detect lsq_overlap_detect_chk #(
  .N_ENT(N_ENT), .AW(UPW + OFSW), .LENW(LENW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_en_i(lat_en_i), .rel_i(rel_i),
  .free_pair_o(free_pair_o), .free_o(free_o), .vld(vld),
  .addr_q(addr_q), .len_q(len_q)
);

// File: tb/lsq_overlap_detect_tb.sv
`timescale 1ns/1ps
module lsq_overlap_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0][11:0] addr_i = '0;
  logic [3:0][3:0]  len_i = '0;
  logic [3:0]       lat_en_i = '0;
  logic [3:0]       rel_i = '0;
  logic [3:0][3:0]  free_pair_o;
  logic [3:0]       free_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsq_overlap_detect u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .len_i(len_i),
    .lat_en_i(lat_en_i), .rel_i(rel_i),
    .free_pair_o(free_pair_o), .free_o(free_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic load(input int k, input logic [11:0] a, input logic [3:0] l);
    @(negedge clk);
    addr_i[k] = a; len_i[k] = l; lat_en_i[k] = 1'b1;
    @(negedge clk);
    lat_en_i = '0;
  endtask

  task automatic drop(input int k);
    @(negedge clk);
    rel_i[k] = 1'b1;
    @(negedge clk);
    rel_i = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    rel_i = '1;
    @(negedge clk);
    rel_i = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 free_o in reset", 16'(free_o), 16'h0);
    chk("R1 rows in reset", 16'(free_pair_o), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 free_o after reset", 16'(free_o), 16'h0);
  endtask

  task automatic t_basic();
    load(0, 12'h100, 4'd4);
    load(1, 12'h104, 4'd4);
    chk("R4 disjoint free_o", 16'(free_o), 16'h3);
    chk("R7 disjoint row0", 16'(free_pair_o[0]), 16'h3);
    load(2, 12'h102, 4'd2);
    chk("R4 overlap free_o", 16'(free_o), 16'h2);
    chk("R7 overlap row0", 16'(free_pair_o[0]), 16'h3);
    chk("R7 overlap row2", 16'(free_pair_o[2]), 16'h6);
    load(3, 12'h202, 4'd2);
    chk("R4 other block free_o", 16'(free_o), 16'hA);
    drop(2);
    chk("R2 release free_o", 16'(free_o), 16'hB);
    chk("R8 row0 after release", 16'(free_pair_o[0]), 16'hB);
  endtask

  task automatic t_spill();
    clear_all();
    chk("R2 cleared", 16'(free_o), 16'h0);
    load(0, 12'h10E, 4'd4);
    load(1, 12'h110, 4'd1);
    load(2, 12'h112, 4'd1);
    chk("R5 spill free_o", 16'(free_o), 16'h4);
    chk("R5 spill row0", 16'(free_pair_o[0]), 16'h5);
    chk("R5 spill row1", 16'(free_pair_o[1]), 16'h6);
    load(3, 12'h112, 4'd0);
    chk("R10 zero len free_o", 16'(free_o), 16'hC);
    chk("R10 zero len row3", 16'(free_pair_o[3]), 16'hF);
    @(negedge clk);
    addr_i[1] = 12'h300; len_i[1] = 4'd8; lat_en_i[1] = 1'b1; rel_i[1] = 1'b1;
    @(negedge clk);
    lat_en_i = '0; rel_i = '0;
    chk("R2 enable beats release", 16'(free_o), 16'hF);
    chk("R6 self bit row1", 16'(free_pair_o[1][1]), 16'h1);
  endtask

  task automatic t_wide_spill();
    clear_all();
    load(0, 12'h10F, 4'd8);
    load(1, 12'h116, 4'd1);
    load(2, 12'h117, 4'd1);
    chk("R5 8-byte spill free_o", 16'(free_o), 16'h4);
    chk("R3 8-byte spill row2", 16'(free_pair_o[2]), 16'h7);
  endtask

  task automatic t_clamp_hold();
    clear_all();
    load(0, 12'h400, 4'd15);
    load(1, 12'h408, 4'd1);
    chk("R3 length clamp free_o", 16'(free_o), 16'h3);
    load(2, 12'h407, 4'd1);
    chk("R3 last byte covered", 16'(free_o), 16'h2);
    @(negedge clk);
    addr_i[1] = 12'h400; len_i[1] = 4'd8;
    repeat (2) @(negedge clk);
    chk("R9 inputs without enable", 16'(free_o), 16'h2);
    chk("R9 row1 unchanged", 16'(free_pair_o[1]), 16'h7);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_spill();
    t_wide_spill();
    t_clamp_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule